// File: doc/BRIEF.md
# Framed Two-Lane Serial ADC Receiver

This block receives conversion results from a converter that acts as the host of its serial link. The converter supplies the data clock, a ready pulse that is high for one clock period, and one or two serial data lanes. There is no chip-select, so the receiver keeps its own count of bits and words. It collects one word per channel for eight channels, presents each word with its channel number and a one-cycle valid strobe, and then stops listening. The clock keeps running after the frame, and the receiver waits for the next ready pulse.

A run-time input chooses between two modes. In single-lane mode all eight channel words arrive one after another on lane 0. In two-lane mode, lane 0 carries channels 0 to 3 while lane 1 carries channels 4 to 7 at the same time, so the frame is half as long. A parameter chooses which edge of the received clock samples the inputs. The falling edge is the default. The rising edge gives an extra half period of margin. All logic runs on that one received clock.

Top module: `adc_frame_rx`

## Requirements
- R1: A low `rst_n` at a sampling edge clears `word_vld`, `frame_done` and `overrun` after that edge, and discards any frame in progress. After reset, the block waits for a ready pulse.
- R2: When `frame_rdy` is high at sampling edge r, bit n of the frame (n counted from 0) is taken at edge r+1+n. Each word arrives most significant bit first.
- R3: In single-lane mode, word k (k = 0..7) is the bits at edges r+1+WORD_W*k through r+WORD_W*(k+1) on lane 0. It is presented with `word_ch` = k, and `word_vld` is high for the one cycle after edge r+WORD_W*(k+1).
- R4: In two-lane mode, lane 0 carries channel k and lane 1 carries channel k+4 (k = 0..3) over the same edges. After edge r+WORD_W*(k+1), channel k is presented for one cycle. Channel k+4 is presented in the cycle after that.
- R5: In single-lane mode, the value on lane 1 has no effect on any output.
- R6: Once the last word of a frame has been captured, data bits are ignored until the next ready pulse. No further word is presented.
- R7: `frame_done` is high for exactly one cycle, the cycle after channel 7 is presented. That is after edge r+8*WORD_W+1 in single-lane mode and after edge r+4*WORD_W+2 in two-lane mode. A frame cut short by an overrun or a reset produces no `frame_done`.
- R8: If `frame_rdy` is high at an edge while a frame is still being captured, the partial frame is dropped, `overrun` is high for the one following cycle, and a new frame starts from that edge. A ready pulse at the first edge after a frame's last bit does not raise `overrun`.
- R9: The lane mode is taken from `two_lane` at the ready edge and held for the whole frame. Changes to `two_lane` during the frame have no effect on it.
- R10: With `SAMPLE_FALL` = 1, all inputs are sampled and all outputs are updated on falling edges of `dclk`. With `SAMPLE_FALL` = 0, rising edges are used. The behaviour relative to those edges is the same in both cases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Data clock driven by the converter |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_rdy | input | 1 | One-period frame start pulse |
| two_lane | input | 1 | 1 selects two-lane mode, 0 selects single-lane mode |
| lane0_in | input | 1 | Serial data lane 0 |
| lane1_in | input | 1 | Serial data lane 1 |
| word_data | output | WORD_W | Received channel word |
| word_ch | output | 3 | Channel number of `word_data` |
| word_vld | output | 1 | One-cycle strobe marking a new word |
| frame_done | output | 1 | One-cycle strobe after channel 7 |
| overrun | output | 1 | One-cycle strobe when a frame is dropped by an early ready pulse |

## Verification
The bench drives every frame into two copies of the block, one for each sampling edge. It checks each word's channel number, its value and its timing, measured in edges from the ready pulse. The data patterns include all-zeros and all-ones words, and lane 1 carries noise in single-lane mode. A receiver with an off-by-one bit count would shift every word or present it one edge late. One that kept counting after the frame would report extra words during the long tail of clock cycles that follows each frame. Further tests cover a ready pulse that interrupts a frame (expect one overrun strobe and no done strobe), a ready pulse at the first edge after the last bit (expect no overrun), a `two_lane` change in the middle of a frame, and a reset in the middle of a frame. A design that read the mode input live would split channels wrongly in the mode-change test. A design that only re-armed on a ready pulse while idle would miss the restart frame in the overrun test.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  localparam int unsigned CHANNELS = 8;
  localparam int unsigned CH_IDX_W = 3;
  localparam int unsigned LANES    = 2;

  typedef logic [CH_IDX_W-1:0] ch_idx_t;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/adc_rx_frame_ctrl.sv
module adc_rx_frame_ctrl
  import adc_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frame_rdy,
  input  logic    dual_req,
  output logic    shift_en,
  output logic    word_end,
  output logic    frame_end,
  output ch_idx_t slot,
  output logic    dual_act,
  output logic    overrun
);
  localparam int unsigned BIT_CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(WORD_W - 1);
  localparam ch_idx_t SLOT_LAST_ONE = ch_idx_t'(CHANNELS - 1);
  localparam ch_idx_t SLOT_LAST_TWO = ch_idx_t'(CHANNELS / LANES - 1);

  cap_state_e        st_q, st_d;
  logic [BIT_CW-1:0] bit_q, bit_d;
  ch_idx_t           slot_q, slot_d;
  logic              dual_q, dual_d;
  logic              ovr_q, ovr_d;
  logic              capturing;
  ch_idx_t           slot_last;

  // next-state process
  always_comb begin
    slot_last = dual_q ? SLOT_LAST_TWO : SLOT_LAST_ONE;
    capturing = (st_q == CAP_RUN) && !frame_rdy;
    word_end  = capturing && (bit_q == BIT_LAST);
    frame_end = word_end && (slot_q == slot_last);

    st_d   = st_q;
    bit_d  = bit_q;
    slot_d = slot_q;
    dual_d = dual_q;
    ovr_d  = 1'b0;

    if (frame_rdy) begin
      // a ready pulse always (re)arms; hitting a live frame is an overrun
      st_d   = CAP_RUN;
      bit_d  = '0;
      slot_d = '0;
      dual_d = dual_req;
      ovr_d  = (st_q == CAP_RUN);
    end else if (capturing) begin
      if (word_end) begin
        bit_d  = '0;
        slot_d = slot_q + 1'b1;
        if (frame_end) begin
          st_d = CAP_IDLE;
        end
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  // register process
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CAP_IDLE;
      bit_q  <= '0;
      slot_q <= '0;
      dual_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
      dual_q <= dual_d;
      ovr_q  <= ovr_d;
    end
  end

  assign shift_en = capturing;
  assign slot     = slot_q;
  assign dual_act = dual_q;
  assign overrun  = ovr_q;

  // R8: an overrun strobe only ever follows an edge that saw ready
  a_r8_overrun_needs_ready : assert property (
    @(posedge clk) disable iff (!rst_n)
    overrun |-> $past(frame_rdy)
  );

  // R9: the frame's lane mode cannot change while words are still arriving
  a_r9_mode_held : assert property (
    @(posedge clk) disable iff (!rst_n)
    (shift_en && !word_end) |=> $stable(dual_act)
  );
endmodule

// File: rtl/adc_rx_lane_shift.sv
module adc_rx_lane_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word_nxt
);
  logic [WORD_W-2:0] sh_q, sh_d;

  // the word completes with the bit arriving at this edge, MSB first
  always_comb begin
    word_nxt = {sh_q, din};
    sh_d     = shift_en ? word_nxt[WORD_W-2:0] : sh_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end
endmodule

// File: rtl/adc_rx_word_emit.sv
module adc_rx_word_emit
  import adc_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_end,
  input  logic              frame_end,
  input  ch_idx_t           slot,
  input  logic              dual_act,
  input  logic [WORD_W-1:0] w_lo,
  input  logic [WORD_W-1:0] w_hi,
  output logic [WORD_W-1:0] out_data,
  output ch_idx_t           out_ch,
  output logic              out_vld,
  output logic              done
);
  localparam ch_idx_t HI_OFFSET = ch_idx_t'(CHANNELS / LANES);

  logic [WORD_W-1:0] data_d, pend_data_q, pend_data_d;
  ch_idx_t           ch_d, pend_ch_q, pend_ch_d;
  logic              vld_d, pend_vld_q, pend_vld_d;
  logic              fin1_q, fin1_dual_q, fin2_q, done_d;

  always_comb begin
    data_d = out_data;
    ch_d   = out_ch;
    vld_d  = 1'b0;
    if (word_end) begin
      data_d = w_lo;
      ch_d   = slot;
      vld_d  = 1'b1;
    end else if (pend_vld_q) begin
      data_d = pend_data_q;
      ch_d   = pend_ch_q;
      vld_d  = 1'b1;
    end
    // upper-lane word waits one cycle behind its lower-lane partner
    pend_vld_d  = word_end && dual_act;
    pend_data_d = w_hi;
    pend_ch_d   = slot | HI_OFFSET;
    done_d      = (fin1_q && !fin1_dual_q) || fin2_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data    <= '0;
      out_ch      <= '0;
      out_vld     <= 1'b0;
      pend_vld_q  <= 1'b0;
      pend_data_q <= '0;
      pend_ch_q   <= '0;
      fin1_q      <= 1'b0;
      fin1_dual_q <= 1'b0;
      fin2_q      <= 1'b0;
      done        <= 1'b0;
    end else begin
      out_data    <= data_d;
      out_ch      <= ch_d;
      out_vld     <= vld_d;
      pend_vld_q  <= pend_vld_d;
      pend_data_q <= pend_data_d;
      pend_ch_q   <= pend_ch_d;
      fin1_q      <= frame_end;
      fin1_dual_q <= frame_end && dual_act;
      fin2_q      <= fin1_q && fin1_dual_q;
      done        <= done_d;
    end
  end

  // R4: a completed pair yields the lower channel, then the upper one
  a_r4_pair_order : assert property (
    @(posedge clk) disable iff (!rst_n)
    (word_end && dual_act) |=> ##1 (out_vld && (out_ch == ($past(slot, 2) | HI_OFFSET)))
  );

  // R4: a new word never lands on the cycle a held upper word is sent
  a_r4_no_collision : assert property (
    @(posedge clk) disable iff (!rst_n)
    !(word_end && pend_vld_q)
  );
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter bit          SAMPLE_FALL = 1'b1
) (
  input  logic              dclk,
  input  logic              rst_n,
  input  logic              frame_rdy,
  input  logic              two_lane,
  input  logic              lane0_in,
  input  logic              lane1_in,
  output logic [WORD_W-1:0] word_data,
  output logic [2:0]        word_ch,
  output logic              word_vld,
  output logic              frame_done,
  output logic              overrun
);
  logic              smp_clk;
  logic              shift_en, word_end, frame_end, dual_act;
  ch_idx_t           slot;
  logic [LANES-1:0]  lane_bit;
  logic [WORD_W-1:0] lane_word [LANES];

  // R10: the sampling edge is fixed at build time
  generate
    if (SAMPLE_FALL) begin : g_fall_edge
      assign smp_clk = ~dclk;
    end else begin : g_rise_edge
      assign smp_clk = dclk;
    end
  endgenerate

  assign lane_bit = {lane1_in, lane0_in};

  adc_rx_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (smp_clk),
    .rst_n     (rst_n),
    .frame_rdy (frame_rdy),
    .dual_req  (two_lane),
    .shift_en  (shift_en),
    .word_end  (word_end),
    .frame_end (frame_end),
    .slot      (slot),
    .dual_act  (dual_act),
    .overrun   (overrun)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_en;
    // lanes above 0 shift only in two-lane frames
    assign lane_en = shift_en && ((l == 0) || dual_act);
    adc_rx_lane_shift #(.WORD_W(WORD_W)) u_shift (
      .clk      (smp_clk),
      .rst_n    (rst_n),
      .shift_en (lane_en),
      .din      (lane_bit[l]),
      .word_nxt (lane_word[l])
    );
  end

  adc_rx_word_emit #(.WORD_W(WORD_W)) u_emit (
    .clk       (smp_clk),
    .rst_n     (rst_n),
    .word_end  (word_end),
    .frame_end (frame_end),
    .slot      (slot),
    .dual_act  (dual_act),
    .w_lo      (lane_word[0]),
    .w_hi      (lane_word[1]),
    .out_data  (word_data),
    .out_ch    (word_ch),
    .out_vld   (word_vld),
    .done      (frame_done)
  );

  // R1: a reset edge leaves every strobe low
  a_r1_reset_quiet : assert property (
    @(posedge smp_clk)
    !rst_n |=> (!word_vld && !frame_done && !overrun)
  );

  // R7: done directly follows the presentation of channel 7
  a_r7_done_after_last : assert property (
    @(posedge smp_clk) disable iff (!rst_n)
    frame_done |-> ($past(word_vld) && ($past(word_ch) == 3'd7))
  );

  // R8: a dropped frame never reports completion in the same cycle
  a_r8_overrun_not_done : assert property (
    @(posedge smp_clk) disable iff (!rst_n)
    overrun |-> !frame_done
  );
endmodule

// File: tb/adc_frame_rx_test.sv
module adc_frame_rx_test;
  localparam int TW = 8;

  logic dclk = 1'b0;
  always #5 dclk = ~dclk;

  // stimulus for the falling-edge copy, driven just after rising edges
  logic rstn_f, rdy_f, tl_f, d0_f, d1_f;
  // same stream delayed half a period for the rising-edge copy
  logic rstn_r, rdy_r, tl_r, d0_r, d1_r;
  always @(negedge dclk) begin
    rstn_r <= rstn_f;
    rdy_r  <= rdy_f;
    tl_r   <= tl_f;
    d0_r   <= d0_f;
    d1_r   <= d1_f;
  end

  logic [TW-1:0] wd_f, wd_r;
  logic [2:0]    wc_f, wc_r;
  logic          wv_f, wv_r, fd_f, fd_r, ov_f, ov_r;

  adc_frame_rx #(.WORD_W(TW), .SAMPLE_FALL(1'b1)) uut (
    .dclk(dclk), .rst_n(rstn_f), .frame_rdy(rdy_f), .two_lane(tl_f),
    .lane0_in(d0_f), .lane1_in(d1_f), .word_data(wd_f), .word_ch(wc_f),
    .word_vld(wv_f), .frame_done(fd_f), .overrun(ov_f)
  );

  adc_frame_rx #(.WORD_W(TW), .SAMPLE_FALL(1'b0)) uut_rise (
    .dclk(dclk), .rst_n(rstn_r), .frame_rdy(rdy_r), .two_lane(tl_r),
    .lane0_in(d0_r), .lane1_in(d1_r), .word_data(wd_r), .word_ch(wc_r),
    .word_vld(wv_r), .frame_done(fd_r), .overrun(ov_r)
  );

  int nvec = 0;
  int nfail = 0;

  // edge counters and ready positions per copy
  int ecnt_f = 0, ecnt_r = 0, rat_f = 0, rat_r = 0;
  always @(negedge dclk) begin
    ecnt_f <= ecnt_f + 1;
    if (rdy_f && rstn_f) rat_f <= ecnt_f + 1;
  end
  always @(posedge dclk) begin
    ecnt_r <= ecnt_r + 1;
    if (rdy_r && rstn_r) rat_r <= ecnt_r + 1;
  end

  // event logs
  int          nw_f, nd_f, no_f, drel_f, nw_r, nd_r, no_r, drel_r;
  logic [2:0]  evf_ch [32];
  logic [TW-1:0] evf_d [32];
  int          evf_rel [32];
  logic [2:0]  evr_ch [32];
  logic [TW-1:0] evr_d [32];
  int          evr_rel [32];

  always @(posedge dclk) begin
    if (wv_f) begin
      if (nw_f < 32) begin
        evf_ch[nw_f] = wc_f; evf_d[nw_f] = wd_f; evf_rel[nw_f] = ecnt_f - rat_f;
      end
      nw_f++;
    end
    if (fd_f) begin drel_f = ecnt_f - rat_f; nd_f++; end
    if (ov_f) no_f++;
  end

  always @(negedge dclk) begin
    if (wv_r) begin
      if (nw_r < 32) begin
        evr_ch[nw_r] = wc_r; evr_d[nw_r] = wd_r; evr_rel[nw_r] = ecnt_r - rat_r;
      end
      nw_r++;
    end
    if (fd_r) begin drel_r = ecnt_r - rat_r; nd_r++; end
    if (ov_r) no_r++;
  end

  function automatic logic [TW-1:0] wval(input int seed, input int ch);
    logic [31:0] t;
    if (seed == 0) return (ch % 2 == 1) ? {TW{1'b1}} : {TW{1'b0}};
    t = seed * 32'h9E37 + ch * 32'h5B + 32'h2D;
    t = t ^ (t >> 7);
    return t[TW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge dclk);
    #1;
  endtask

  task automatic clear_ev();
    nw_f = 0; nd_f = 0; no_f = 0; drel_f = -1;
    nw_r = 0; nd_r = 0; no_r = 0; drel_r = -1;
  endtask

  task automatic tail(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      rdy_f = 1'b0;
      d0_f = 1'($urandom);
      d1_f = 1'($urandom);
    end
  endtask

  // ready pulse, then nbits data bits (all of them when nbits < 0)
  task automatic drive_frame(input bit dual, input int seed, input int nbits, input int flip_at);
    int total;
    logic [TW-1:0] w0, w1;
    total = dual ? 4 * TW : 8 * TW;
    if (nbits >= 0 && nbits < total) total = nbits;
    tick();
    rdy_f = 1'b1; tl_f = dual;
    d0_f = 1'($urandom); d1_f = 1'($urandom);
    for (int b = 0; b < total; b++) begin
      tick();
      rdy_f = 1'b0;
      if (b == flip_at) tl_f = !dual;
      w0 = wval(seed, b / TW);
      w1 = wval(seed, b / TW + 4);
      d0_f = w0[TW - 1 - b % TW];
      d1_f = dual ? w1[TW - 1 - b % TW] : 1'($urandom);
    end
  endtask

  task automatic check_words(input int inst, input bit dual, input int seed,
                             input int base, input int n, input bit chk_rel);
    logic [2:0] c;
    logic [TW-1:0] d;
    int r, ech, erel;
    string req;
    req = dual ? "R2/R4/R10" : "R2/R3/R5/R10";
    for (int j = 0; j < n; j++) begin
      if (inst == 0) begin c = evf_ch[base+j]; d = evf_d[base+j]; r = evf_rel[base+j]; end
      else begin c = evr_ch[base+j]; d = evr_d[base+j]; r = evr_rel[base+j]; end
      if (dual) begin
        ech  = (j % 2 == 1) ? j / 2 + 4 : j / 2;
        erel = TW * (j / 2 + 1) + j % 2;
      end else begin
        ech  = j;
        erel = TW * (j + 1);
      end
      chk(c == 3'(ech), req, $sformatf("copy%0d word%0d channel", inst, base + j), c, ech);
      chk(d == wval(seed, ech), req, $sformatf("copy%0d word%0d data", inst, base + j), d, wval(seed, ech));
      if (chk_rel)
        chk(r == erel, req, $sformatf("copy%0d word%0d edge offset", inst, base + j), r, erel);
    end
  endtask

  task automatic check_counts(input int inst, input int ew, input int ed, input int eo);
    int w, dn, o;
    w  = (inst == 0) ? nw_f : nw_r;
    dn = (inst == 0) ? nd_f : nd_r;
    o  = (inst == 0) ? no_f : no_r;
    chk(w == ew, "R6", $sformatf("copy%0d word count", inst), w, ew);
    chk(dn == ed, "R7", $sformatf("copy%0d done count", inst), dn, ed);
    chk(o == eo, "R8", $sformatf("copy%0d overrun count", inst), o, eo);
  endtask

  task automatic check_done_rel(input int inst, input bit dual);
    int r, e;
    r = (inst == 0) ? drel_f : drel_r;
    e = dual ? 4 * TW + 2 : 8 * TW + 1;
    chk(r == e, "R7", $sformatf("copy%0d done edge offset", inst), r, e);
  endtask

  task automatic check_idle_outputs(input string what);
    chk(!wv_f && !fd_f && !ov_f, "R1", {what, " falling copy strobes"}, {wv_f, fd_f, ov_f}, 0);
    chk(!wv_r && !fd_r && !ov_r, "R1", {what, " rising copy strobes"}, {wv_r, fd_r, ov_r}, 0);
  endtask

  task automatic full_frame_test(input bit dual, input int seed, input int flip_at);
    clear_ev();
    drive_frame(dual, seed, -1, flip_at);
    tail(3 * TW);
    for (int inst = 0; inst < 2; inst++) begin
      check_counts(inst, 8, 1, 0);
      check_words(inst, dual, seed, 0, 8, 1'b1);
      check_done_rel(inst, dual);
    end
  endtask

  initial begin
    rstn_f = 1'b0; rdy_f = 1'b0; tl_f = 1'b0; d0_f = 1'b0; d1_f = 1'b0;
    clear_ev();
    repeat (4) tick();
    check_idle_outputs("after reset");
    rstn_f = 1'b1;
    tick(); tick();

    // R3 / R5: single-lane frames, lane 1 carries noise
    for (int s = 0; s < 4; s++) full_frame_test(1'b0, s, -1);
    // R4: two-lane frames
    for (int s = 0; s < 4; s++) full_frame_test(1'b1, s + 10, -1);
    // R9: mode input flips mid-frame, both directions
    full_frame_test(1'b1, 21, 5);
    full_frame_test(1'b0, 22, TW + 2);

    // R8: early ready drops the frame after two words and three bits
    clear_ev();
    drive_frame(1'b0, 5, 2 * TW + 3, -1);
    drive_frame(1'b0, 6, -1, -1);
    tail(3 * TW);
    for (int inst = 0; inst < 2; inst++) begin
      check_counts(inst, 10, 1, 1);
      check_words(inst, 1'b0, 5, 0, 2, 1'b1);
      check_words(inst, 1'b0, 6, 2, 8, 1'b1);
      check_done_rel(inst, 1'b0);
    end

    // R8: ready at the first edge after the last bit is not an overrun
    clear_ev();
    drive_frame(1'b1, 7, -1, -1);
    drive_frame(1'b1, 8, -1, -1);
    tail(3 * TW);
    for (int inst = 0; inst < 2; inst++) begin
      check_counts(inst, 16, 2, 0);
      check_words(inst, 1'b1, 7, 0, 8, 1'b0);
      check_words(inst, 1'b1, 8, 8, 8, 1'b1);
    end

    // R1: reset in the middle of a frame discards it
    clear_ev();
    drive_frame(1'b0, 9, 3 * TW + 1, -1);
    tick(); rstn_f = 1'b0;
    tick(); tick();
    check_idle_outputs("reset mid-frame");
    rstn_f = 1'b1;
    tick(); tick();
    clear_ev();
    tail(10 * TW);
    for (int inst = 0; inst < 2; inst++) check_counts(inst, 0, 0, 0);

    // R1 / R6: a clean frame still works after that
    full_frame_test(1'b0, 30, -1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge dclk);
    nfail++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule